// File: doc/BRIEF.md
# VME to Wishbone Direct-Access Mapper

This block turns single VME slave cycles into single Wishbone master transfers. One 32-bit control word decides the mode. While the word holds all ones, the block is in bridge mode. In that mode it leaves the window alone and only shows the mode on `mode_o`. Any other value in the word selects direct mode, and that value is also the Wishbone base address. In direct mode, each A32 cycle that falls in the slot's window is forwarded as exactly one Wishbone read or write. Its address is the offset into the window plus the base.

The VME side arrives already decoded. A one-cycle strobe `vme_req_i` comes with the address, the address modifier, the write flag and the write data. The geographic slot number comes from a static input. The block answers with a one-cycle `vme_ack_o` and read data. A strobe that matches neither the control word nor an enabled window gets no answer.

A small state machine handles each accepted strobe. Its states are `ST_IDLE`, `ST_REG_ACK` and `ST_BUS_WAIT`. It has four transitions:

- `T_CTL`: from `ST_IDLE` to `ST_REG_ACK`, on a control-word strobe.
- `T_WIN`: from `ST_IDLE` to `ST_BUS_WAIT`, on a window strobe in direct mode.
- `T_CTL_DONE`: from `ST_REG_ACK` back to `ST_IDLE`, always after one cycle.
- `T_WB_DONE`: from `ST_BUS_WAIT` back to `ST_IDLE`, on Wishbone ACK.

Top module: `vme_wb_direct_map`

## Requirements
- R1: After reset the control word is 0xFFFFFFFF. `mode_o` is low, and no Wishbone cycle or VME acknowledge is active.
- R2: A control-word strobe that writes a value other than 0xFFFFFFFF raises `mode_o` on the next cycle. The value is stored as the Wishbone base address.
- R3: Writing 0xFFFFFFFF to the control word drops `mode_o` on the next cycle. With no control write, `mode_o` never changes.
- R4: The control word is hit only when the address modifier is 0x39 and the address bits [23:0] equal slot*0x400 + 0x4. Bits [31:24] are not compared. Any other modifier or address leaves the word unchanged and gets no acknowledge.
- R5: A window hit needs all of the following: `mode_o` high, modifier 0x09, and address bits [31:28] equal to the slot number. The Wishbone address is then address - slot*0x10000000 + base, taken modulo 2^32.
- R6: Each window hit produces exactly one Wishbone transfer. CYC and STB rise together, with SEL = 4'b1111 and WE and write data copied from the VME cycle. They are held unchanged until ACK, and they drop on the cycle after ACK.
- R7: In the cycle where Wishbone ACK is seen, `vme_ack_o` is high. For a read, `vme_rdata_o` in that cycle equals the Wishbone read data.
- R8: Window-address strobes while `mode_o` is low start no Wishbone cycle and get no acknowledge.
- R9: Strobes that arrive while a Wishbone transfer is outstanding are ignored. They change neither the transfer in progress nor the transfer count.
- R10: A control-word access is acknowledged on the cycle after its strobe, in either mode. `vme_rdata_o` then carries the control word's value, which after a write is the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_i | input | 4 | Static geographic slot number |
| vme_req_i | input | 1 | One-cycle strobe for a decoded VME cycle |
| vme_addr_i | input | 32 | VME address |
| vme_am_i | input | 6 | VME address modifier |
| vme_we_i | input | 1 | 1 = write cycle |
| vme_wdata_i | input | 32 | VME write data |
| vme_rdata_o | output | 32 | VME read data, valid with `vme_ack_o` |
| vme_ack_o | output | 1 | One-cycle acknowledge of an accepted cycle |
| mode_o | output | 1 | High in direct-access mode |
| wb_cyc_o | output | 1 | Wishbone CYC |
| wb_stb_o | output | 1 | Wishbone STB |
| wb_we_o | output | 1 | Wishbone WE |
| wb_sel_o | output | 4 | Wishbone byte selects |
| wb_adr_o | output | 32 | Wishbone byte address |
| wb_dat_o | output | 32 | Wishbone write data |
| wb_dat_i | input | 32 | Wishbone read data |
| wb_ack_i | input | 1 | Wishbone ACK |

## Verification
The bench goes after several corner cases, and each one shows up as a distinct fault:

- **Window edges.** The last word of the slot's window and the first word above it are both tried. A mapper that compares too few address bits would forward the out-of-window cycle.
- **Base plus offset overflow.** A base near the top of the address space is used, so the sum wraps past 2^32. A design with a wrong carry or wrong slot subtraction would emit a misplaced Wishbone address.
- **Strobes during a transfer.** Strobes are injected while an ACK is still pending. A machine that re-arms on them would show a second CYC rise or a changed address.
- **Wrong control decode.** Control writes with the wrong modifier, and control addresses with junk upper bits, are tried. These catch a decode that is too loose or too strict.
- **Mode exit.** After writing all ones, window cycles must go unanswered. This catches a stale mode flag.

// File: rtl/vme_wb_map_pkg.sv
package vme_wb_map_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REG_ACK,
        ST_BUS_WAIT
    } map_state_e;

    typedef enum logic [1:0] {
        HIT_NONE,
        HIT_CTL,
        HIT_WIN
    } hit_e;

    localparam logic [5:0] AM_CTL_SPACE = 6'h39;
    localparam logic [5:0] AM_WIN_SPACE = 6'h09;

endpackage

// File: rtl/vme_map_decode.sv
module vme_map_decode
    import vme_wb_map_pkg::*;
#(
    parameter int AW               = 32,
    parameter int SLOT_W           = 4,
    parameter int WIN_SHIFT        = 28,
    parameter int CTL_SPACE_W      = 24,
    parameter int CTL_STRIDE_SHIFT = 10,
    parameter int CTL_OFFSET       = 4
) (
    input  logic [AW-1:0]     addr_i,
    input  logic [5:0]        am_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              mode_i,
    output hit_e              hit_o,
    output logic [AW-1:0]     offset_o
);
    localparam int TAG_W = AW - WIN_SHIFT;

    logic [CTL_SPACE_W-1:0] ctl_addr;
    logic [TAG_W-1:0]       win_tag;
    logic                   ctl_match;
    logic                   win_match;

    always_comb begin
        ctl_addr  = (CTL_SPACE_W'(slot_i) << CTL_STRIDE_SHIFT) + CTL_SPACE_W'(CTL_OFFSET);
        win_tag   = TAG_W'(slot_i);
        ctl_match = (am_i == AM_CTL_SPACE) && (addr_i[CTL_SPACE_W-1:0] == ctl_addr);
        win_match = (am_i == AM_WIN_SPACE) && (addr_i[AW-1:WIN_SHIFT] == win_tag);
        offset_o  = {{TAG_W{1'b0}}, addr_i[WIN_SHIFT-1:0]};
        if (ctl_match) begin
            hit_o = HIT_CTL;
        end else if (win_match && mode_i) begin
            hit_o = HIT_WIN;
        end else begin
            hit_o = HIT_NONE;
        end
    end

endmodule

// File: rtl/vme_map_ctl.sv
module vme_map_ctl #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] ctl_q_o,
    output logic          mode_o
);
    logic [DW-1:0] ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '1;
        end else if (wr_en_i) begin
            ctl_q <= wr_data_i;
        end
    end

    assign ctl_q_o = ctl_q;
    assign mode_o  = (ctl_q != '1);

endmodule

// File: rtl/vme_map_fsm.sv
module vme_map_fsm
    import vme_wb_map_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int SEL_W = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  hit_e             hit_i,
    input  logic             we_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [AW-1:0]    offset_i,
    input  logic [DW-1:0]    ctl_q_i,
    output logic             ctl_wr_en_o,
    output logic [DW-1:0]    ctl_wr_data_o,
    output logic             vme_ack_o,
    output logic [DW-1:0]    vme_rdata_o,
    output logic             wb_cyc_o,
    output logic             wb_stb_o,
    output logic             wb_we_o,
    output logic [SEL_W-1:0] wb_sel_o,
    output logic [AW-1:0]    wb_adr_o,
    output logic [DW-1:0]    wb_dat_o,
    input  logic [DW-1:0]    wb_dat_i,
    input  logic             wb_ack_i
);
    map_state_e state_q;
    map_state_e state_d;
    logic          take_win;
    logic [AW-1:0] adr_q;
    logic          we_q;
    logic [DW-1:0] dat_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: T_CTL, T_WIN, T_CTL_DONE, T_WB_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i && hit_i == HIT_CTL) begin
                    state_d = ST_REG_ACK;
                end else if (req_i && hit_i == HIT_WIN) begin
                    state_d = ST_BUS_WAIT;
                end
            end
            ST_REG_ACK:  state_d = ST_IDLE;
            ST_BUS_WAIT: if (wb_ack_i) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Transfer capture: the base is read from the control word at acceptance
    assign take_win = (state_q == ST_IDLE) && req_i && (hit_i == HIT_WIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adr_q <= '0;
            we_q  <= 1'b0;
            dat_q <= '0;
        end else if (take_win) begin
            adr_q <= offset_i + AW'(ctl_q_i);
            we_q  <= we_i;
            dat_q <= wdata_i;
        end
    end

    // Outputs
    always_comb begin
        ctl_wr_en_o   = (state_q == ST_IDLE) && req_i && (hit_i == HIT_CTL) && we_i;
        ctl_wr_data_o = wdata_i;
        wb_cyc_o      = 1'b0;
        wb_stb_o      = 1'b0;
        wb_sel_o      = '0;
        vme_ack_o     = 1'b0;
        vme_rdata_o   = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_REG_ACK: begin
                vme_ack_o   = 1'b1;
                vme_rdata_o = ctl_q_i;
            end
            ST_BUS_WAIT: begin
                wb_cyc_o  = 1'b1;
                wb_stb_o  = 1'b1;
                wb_sel_o  = '1;
                vme_ack_o = wb_ack_i;
                if (wb_ack_i && !we_q) begin
                    vme_rdata_o = wb_dat_i;
                end
            end
            default: ;
        endcase
        wb_we_o  = we_q && (state_q == ST_BUS_WAIT);
        wb_adr_o = adr_q;
        wb_dat_o = dat_q;
    end

endmodule

// File: rtl/vme_wb_direct_map.sv
module vme_wb_direct_map
    import vme_wb_map_pkg::*;
#(
    parameter int AW               = 32,
    parameter int DW               = 32,
    parameter int SLOT_W           = 4,
    parameter int WIN_SHIFT        = 28,
    parameter int CTL_SPACE_W      = 24,
    parameter int CTL_STRIDE_SHIFT = 10,
    parameter int CTL_OFFSET       = 4,
    parameter int SEL_W            = DW / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              vme_req_i,
    input  logic [AW-1:0]     vme_addr_i,
    input  logic [5:0]        vme_am_i,
    input  logic              vme_we_i,
    input  logic [DW-1:0]     vme_wdata_i,
    output logic [DW-1:0]     vme_rdata_o,
    output logic              vme_ack_o,
    output logic              mode_o,
    output logic              wb_cyc_o,
    output logic              wb_stb_o,
    output logic              wb_we_o,
    output logic [SEL_W-1:0]  wb_sel_o,
    output logic [AW-1:0]     wb_adr_o,
    output logic [DW-1:0]     wb_dat_o,
    input  logic [DW-1:0]     wb_dat_i,
    input  logic              wb_ack_i
);
    hit_e          hit;
    logic [AW-1:0] offset;
    logic [DW-1:0] ctl_q;
    logic          ctl_wr_en;
    logic [DW-1:0] ctl_wr_data;

    vme_map_decode #(
        .AW(AW), .SLOT_W(SLOT_W), .WIN_SHIFT(WIN_SHIFT),
        .CTL_SPACE_W(CTL_SPACE_W), .CTL_STRIDE_SHIFT(CTL_STRIDE_SHIFT),
        .CTL_OFFSET(CTL_OFFSET)
    ) u_decode (
        .addr_i  (vme_addr_i),
        .am_i    (vme_am_i),
        .slot_i  (slot_i),
        .mode_i  (mode_o),
        .hit_o   (hit),
        .offset_o(offset)
    );

    vme_map_ctl #(.DW(DW)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (ctl_wr_en),
        .wr_data_i(ctl_wr_data),
        .ctl_q_o  (ctl_q),
        .mode_o   (mode_o)
    );

    vme_map_fsm #(.AW(AW), .DW(DW), .SEL_W(SEL_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (vme_req_i),
        .hit_i        (hit),
        .we_i         (vme_we_i),
        .wdata_i      (vme_wdata_i),
        .offset_i     (offset),
        .ctl_q_i      (ctl_q),
        .ctl_wr_en_o  (ctl_wr_en),
        .ctl_wr_data_o(ctl_wr_data),
        .vme_ack_o    (vme_ack_o),
        .vme_rdata_o  (vme_rdata_o),
        .wb_cyc_o     (wb_cyc_o),
        .wb_stb_o     (wb_stb_o),
        .wb_we_o      (wb_we_o),
        .wb_sel_o     (wb_sel_o),
        .wb_adr_o     (wb_adr_o),
        .wb_dat_o     (wb_dat_o),
        .wb_dat_i     (wb_dat_i),
        .wb_ack_i     (wb_ack_i)
    );

endmodule

// File: rtl/vme_wb_direct_map_chk.sv
module vme_wb_direct_map_chk #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int SEL_W = DW / 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vme_req_i,
    input logic [DW-1:0]    vme_rdata_o,
    input logic             vme_ack_o,
    input logic             mode_o,
    input logic             wb_cyc_o,
    input logic             wb_stb_o,
    input logic             wb_we_o,
    input logic [SEL_W-1:0] wb_sel_o,
    input logic [AW-1:0]    wb_adr_o,
    input logic [DW-1:0]    wb_dat_i,
    input logic             wb_ack_i
);
    AST_CYC_STB_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc_o == wb_stb_o); // R6

    AST_SEL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc_o |-> wb_sel_o == '1); // R6

    AST_HOLD_TO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_o && !wb_ack_i) |=> (wb_cyc_o && $stable(wb_adr_o) && $stable(wb_we_o))); // R6

    AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_o && wb_ack_i) |=> !wb_cyc_o); // R6

    AST_ACK_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_o && wb_ack_i) |-> vme_ack_o); // R7

    AST_READ_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_o && wb_ack_i && !wb_we_o) |-> (vme_rdata_o == wb_dat_i)); // R7

    AST_NO_CYC_BRIDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_cyc_o) |-> mode_o); // R8

    AST_CTL_ACK_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (vme_ack_o && !wb_cyc_o) |-> $past(vme_req_i)); // R10

    AST_MODE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(vme_req_i) |-> $stable(mode_o)); // R3

endmodule

bind vme_wb_direct_map vme_wb_direct_map_chk #(.AW(AW), .DW(DW), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/vme_wb_direct_map_tb.sv
module vme_wb_direct_map_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  slot = 4'd5;
    logic        req = 1'b0;
    logic [31:0] addr = '0;
    logic [5:0]  am = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ack;
    logic        mode;
    logic        cyc, stb, wbwe;
    logic [3:0]  sel;
    logic [31:0] wadr, wdo;
    logic [31:0] wdi = '0;
    logic        wack = 1'b0;

    int checks = 0;
    int fails  = 0;
    int rises  = 0;
    logic cyc_prev = 1'b0;
    logic [31:0] ref_ctl = 32'hFFFF_FFFF;

    always #4 clk = ~clk; // 125 MHz

    vme_wb_direct_map u_dut (
        .clk(clk), .rst_n(rst_n), .slot_i(slot),
        .vme_req_i(req), .vme_addr_i(addr), .vme_am_i(am), .vme_we_i(we),
        .vme_wdata_i(wdata), .vme_rdata_o(rdata), .vme_ack_o(ack), .mode_o(mode),
        .wb_cyc_o(cyc), .wb_stb_o(stb), .wb_we_o(wbwe), .wb_sel_o(sel),
        .wb_adr_o(wadr), .wb_dat_o(wdo), .wb_dat_i(wdi), .wb_ack_i(wack)
    );

    always @(posedge clk) begin
        if (cyc && !cyc_prev) rises++;
        cyc_prev <= cyc;
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic int classify(input logic [31:0] a, input logic [5:0] m);
        if (m == 6'h39 && a[23:0] == ({20'd0, slot} * 24'h400 + 24'h4)) return 1;
        if (m == 6'h09 && a[31:28] == slot && ref_ctl != 32'hFFFF_FFFF) return 2;
        return 0;
    endfunction

    function automatic logic [31:0] exp_adr(input logic [31:0] a);
        return a - ({28'd0, slot} << 28) + ref_ctl;
    endfunction

    function automatic logic [31:0] slave_data(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A3C_96E1;
    endfunction

    task automatic access(input logic [31:0] a, input logic [5:0] m, input bit w,
                          input logic [31:0] d, input int lat, input bit intrude);
        int kind;
        int r0;
        logic [31:0] ea;
        kind = classify(a, m);
        ea   = exp_adr(a);
        @(negedge clk);
        req = 1'b1; addr = a; am = m; we = w; wdata = d;
        @(negedge clk);
        req = 1'b0;
        #1;
        if (kind == 1) begin
            if (w) ref_ctl = d;
            chk(ack === 1'b1, "R10", "ctl ack", {31'd0, ack}, 32'd1);
            chk(rdata === ref_ctl, "R10", "ctl readback", rdata, ref_ctl);
            chk(cyc === 1'b0, "R4", "no wb on ctl", {31'd0, cyc}, 32'd0);
            @(negedge clk); #1;
            chk(mode === (ref_ctl != 32'hFFFF_FFFF), w ? (d == 32'hFFFF_FFFF ? "R3" : "R2") : "R10",
                "mode after ctl", {31'd0, mode}, {31'd0, ref_ctl != 32'hFFFF_FFFF});
            chk(ack === 1'b0, "R10", "ack one cycle", {31'd0, ack}, 32'd0);
        end else if (kind == 2) begin
            r0 = rises;
            chk(cyc === 1'b1 && stb === 1'b1, "R6", "cyc/stb up", {30'd0, cyc, stb}, 32'd3);
            chk(sel === 4'hF, "R6", "sel", {28'd0, sel}, 32'hF);
            chk(wadr === ea, "R5", "wb address", wadr, ea);
            chk(wbwe === w, "R6", "wb we", {31'd0, wbwe}, {31'd0, w});
            if (w) chk(wdo === d, "R6", "wb wdata", wdo, d);
            for (int i = 0; i < lat; i++) begin
                if (intrude && i == 0) begin
                    req = 1'b1; addr = {slot, 28'h0000100}; am = 6'h09; we = ~w;
                end
                chk(ack === 1'b0, "R7", "no early ack", {31'd0, ack}, 32'd0);
                @(negedge clk);
                req = 1'b0;
                #1;
                chk(cyc === 1'b1 && wadr === ea, intrude ? "R9" : "R6", "held until ack", wadr, ea);
            end
            wack = 1'b1; wdi = slave_data(ea);
            #1;
            chk(ack === 1'b1, "R7", "ack with wb ack", {31'd0, ack}, 32'd1);
            if (!w) chk(rdata === slave_data(ea), "R7", "read data", rdata, slave_data(ea));
            @(negedge clk);
            wack = 1'b0;
            #1;
            chk(cyc === 1'b0 && ack === 1'b0, "R6", "release after ack", {30'd0, cyc, ack}, 32'd0);
            repeat (2) @(negedge clk);
            #1;
            chk(rises - r0 == 1, intrude ? "R9" : "R6", "one transfer", rises - r0, 32'd1);
        end else begin
            r0 = rises;
            for (int i = 0; i < 3; i++) begin
                chk(ack === 1'b0 && cyc === 1'b0, ref_ctl == 32'hFFFF_FFFF ? "R8" : "R4",
                    "ignored strobe", {30'd0, ack, cyc}, 32'd0);
                @(negedge clk); #1;
            end
            chk(rises == r0, "R8", "no transfer", rises - r0, 32'd0);
            chk(mode === (ref_ctl != 32'hFFFF_FFFF), "R3", "mode steady",
                {31'd0, mode}, {31'd0, ref_ctl != 32'hFFFF_FFFF});
        end
    endtask

    function automatic logic [31:0] ctl_addr();
        return {20'd0, slot} * 32'h400 + 32'h4;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20417));
        repeat (3) @(negedge clk);
        #1;
        chk(mode === 1'b0, "R1", "reset mode", {31'd0, mode}, 32'd0);
        chk(cyc === 1'b0 && ack === 1'b0, "R1", "reset idle", {30'd0, cyc, ack}, 32'd0);
        rst_n = 1'b1;
        // R1/R10 readback of reset value in bridge mode
        access(ctl_addr(), 6'h39, 1'b0, 32'h0, 0, 1'b0);
        // R8 window while bridge mode
        access(32'h5000_0010, 6'h09, 1'b0, 32'h0, 0, 1'b0);
        // R4 wrong modifier on control address
        access(ctl_addr(), 6'h3D, 1'b1, 32'h1234_0000, 0, 1'b0);
        access(ctl_addr(), 6'h39, 1'b0, 32'h0, 0, 1'b0);
        // R2 enter direct mode; R4 upper bits ignored
        access(32'hAB00_0000 | ctl_addr(), 6'h39, 1'b1, 32'h0400_00C0, 0, 1'b0);
        access(32'h5000_0008, 6'h09, 1'b0, 32'h0, 2, 1'b0);
        access(32'h5000_0004, 6'h09, 1'b1, 32'hFFFF_FFFF, 0, 1'b0);
        // R5 window edges
        access(32'h5FFF_FFFC, 6'h09, 1'b0, 32'h0, 1, 1'b0);
        access(32'h6000_0000, 6'h09, 1'b0, 32'h0, 0, 1'b0);
        access(32'h4FFF_FFFC, 6'h09, 1'b0, 32'h0, 0, 1'b0);
        // R5 wrap of base plus offset
        access(ctl_addr(), 6'h39, 1'b1, 32'hFFFF_FFF0, 0, 1'b0);
        access(32'h5000_0020, 6'h09, 1'b1, 32'hCAFE_0001, 1, 1'b0);
        // R9 strobe while outstanding
        access(32'h5000_0040, 6'h09, 1'b0, 32'h0, 3, 1'b1);
        // R3 leave direct mode, window then ignored
        access(ctl_addr(), 6'h39, 1'b1, 32'hFFFF_FFFF, 0, 1'b0);
        access(32'h5000_0008, 6'h09, 1'b0, 32'h0, 0, 1'b0);
        // different slot (static change while idle)
        slot = 4'd2;
        access(ctl_addr(), 6'h39, 1'b1, 32'h0001_0000, 0, 1'b0);
        access(32'h2000_0100, 6'h09, 1'b0, 32'h0, 0, 1'b0);
        // constrained random mix
        for (int n = 0; n < 80; n++) begin
            int sel_r;
            logic [31:0] ra;
            sel_r = $urandom % 10;
            ra = {slot, 28'h0} | ($urandom & 32'h0FFF_FFFC);
            case (sel_r)
                0: access(ctl_addr(), 6'h39, 1'b1,
                          ($urandom % 3 == 0) ? 32'hFFFF_FFFF : $urandom, 0, 1'b0);
                1: access(ctl_addr(), 6'h39, 1'b0, 32'h0, 0, 1'b0);
                7: access({slot + 4'd1, ra[27:0]}, 6'h09, 1'b0, 32'h0, 0, 1'b0);
                8: access(ra, 6'h0D, 1'b1, $urandom, 0, 1'b0);
                9: access(ctl_addr(), 6'h09, 1'b1, $urandom, 0, 1'b0);
                default: access(ra, 6'h09, 1'($urandom % 2), $urandom,
                                int'($urandom % 4), 1'($urandom % 4 == 0));
            endcase
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule